// File: doc/BRIEF.md
# Programmable Watchdog Reset Timer

This block is a free-running watchdog. A prescaler divides the system clock into a coarse timebase tick, nominally one tick per 100 ms. A tick counter, loaded from a 5-bit period code, counts those ticks down. Software configures the block through a write-only register port with an address, data and a write strobe. One register holds the period code and an enable bit. The other register accepts a restart pattern. When the count runs out, the block sends a one-cycle expiry event and reloads itself. If the enable bit is set, a reset request to the chip's reset controller accompanies that event.

Writing the restart pattern is the only way to load a newly written period code into the counter. A rising edge on the monitored system reset line also restarts the counter, and so does an asserted supply-low input, which holds the watchdog idle. The all-ones period code stops the counter, so it never expires. The counter keeps running whether or not the enable bit is set.

Top module: `wdog_timer`

## Requirements
- R1: One timebase tick is CLK_PER_TICK clock cycles. For codes 1 to 30 the period is code ticks, and code 0 counts as one tick. The first expiry is set on the clock edge period × CLK_PER_TICK edges after the restart edge.
- R2: A write to address 0x0A stores data[4:0] as the period code and data[7] as the enable. Data bits 6 and 5 are ignored.
- R3: A write to address 0x09 whose data[3:0] equals 4'b1010 restarts both the prescaler and the counter, and loads the stored period code. Data bits 7 to 4 are ignored.
- R4: A write to 0x09 with any other low nibble has no effect on the expiry timing. So does a write to any address other than 0x09 or 0x0A.
- R5: A write to 0x0A on its own does not change the running count or the period that is reloaded. The new code takes effect only at the next restart.
- R6: On expiry, wd_expire is high for exactly one cycle. The counter reloads the active period and keeps running, so expiries repeat every period × CLK_PER_TICK cycles.
- R7: wd_rst_req is high in the same cycle as wd_expire, but only when the enable bit is 1. With the enable at 0, wd_expire still pulses and wd_rst_req stays low.
- R8: While the active period code is 5'b11111, the counter is halted and no expiry occurs.
- R9: A rising edge on sys_rst_n restarts the counter with the stored code, at the first clock edge where sys_rst_n is sampled high.
- R10: While supply_low is high, the counter is held in restart and neither output pulses. The first expiry follows period × CLK_PER_TICK edges after the last edge on which supply_low was high.
- R11: After rst_n is released, the stored and active codes equal RESET_CODE and the enable is 0. Counting starts from the release, as it does after a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| sys_rst_n | input | 1 | Monitored system reset line; its rising edge restarts the counter |
| supply_low | input | 1 | Supply-low indication; holds the watchdog idle |
| wd_expire | output | 1 | One-cycle expiry event |
| wd_rst_req | output | 1 | One-cycle reset request, given on an expiry while enabled |

## Verification
The assertions assume that CLK_PER_TICK is at least 2, so that two expiries can never fall on neighbouring cycles. They also assume that wr_en, wr_addr, wr_data, sys_rst_n and supply_low are synchronous to clk and stable around the rising edge. The stimulus meets this by changing every input on the falling clock edge and issuing at most one register write per cycle. Each timing check counts clock edges from the edge on which a restart took effect. That edge is a kick write, the first high sample of sys_rst_n, the last high sample of supply_low, or the release of rst_n.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CODE_W = 5;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t HALT_CODE = '1;

  // Number of timebase ticks in one period for a given code.
  function automatic code_t ticks_for(input code_t code);
    return (code == '0) ? code_t'(1) : code;
  endfunction

  function automatic logic is_halt(input code_t code);
    return code == HALT_CODE;
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter int          DATA_W       = 8,
  parameter logic [7:0]  CFG_ADDR     = 8'h0A,
  parameter logic [7:0]  KICK_ADDR    = 8'h09,
  parameter logic [3:0]  KICK_PATTERN = 4'b1010,
  parameter int          EN_BIT       = 7,
  parameter code_t       RESET_CODE   = code_t'(10)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output code_t             cfg_code,
  output logic              cfg_en,
  output logic              kick
);
  logic cfg_hit;
  logic unused_data_bits;

  assign cfg_hit = wr_en && (wr_addr == ADDR_W'(CFG_ADDR));
  assign kick    = wr_en && (wr_addr == ADDR_W'(KICK_ADDR))
                   && (wr_data[3:0] == KICK_PATTERN);
  assign unused_data_bits = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_code <= RESET_CODE;
      cfg_en   <= 1'b0;
    end else if (cfg_hit) begin
      cfg_code <= wr_data[CODE_W-1:0];
      cfg_en   <= wr_data[EN_BIT];
    end
  end
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int CLK_PER_TICK = 5_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic tick
);
  localparam int W = (CLK_PER_TICK > 2) ? $clog2(CLK_PER_TICK) : 1;
  localparam logic [W-1:0] LAST = W'(CLK_PER_TICK - 1);

  logic [W-1:0] cnt;

  assign tick = !clear && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clear || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter code_t RESET_CODE = code_t'(10)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  code_t new_code,
  input  logic  tick,
  output code_t active_code,
  output logic  fire
);
  code_t remain;

  assign fire = tick && !restart && !is_halt(active_code) && (remain <= code_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_code <= RESET_CODE;
      remain      <= ticks_for(RESET_CODE);
    end else if (restart) begin
      active_code <= new_code;
      remain      <= ticks_for(new_code);
    end else if (tick && !is_halt(active_code)) begin
      if (remain <= code_t'(1)) remain <= ticks_for(active_code);
      else                      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int    CLK_PER_TICK = 5_000_000,
  parameter code_t RESET_CODE   = code_t'(10)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       sys_rst_n,
  input  logic       supply_low,
  output logic       wd_expire,
  output logic       wd_rst_req
);
  code_t cfg_code_w;
  code_t active_code_w;
  logic  cfg_en_w;
  logic  kick_w;
  logic  tick_w;
  logic  fire_w;
  logic  restart_w;
  logic  sys_rst_q;
  logic  sys_rise_w;

  wdog_regs #(.RESET_CODE(RESET_CODE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_code(cfg_code_w), .cfg_en(cfg_en_w), .kick(kick_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sys_rst_q <= 1'b1;
    else        sys_rst_q <= sys_rst_n;
  end
  assign sys_rise_w = sys_rst_n && !sys_rst_q;
  assign restart_w  = kick_w || sys_rise_w || supply_low;

  wdog_prescale #(.CLK_PER_TICK(CLK_PER_TICK)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(restart_w), .tick(tick_w)
  );

  wdog_count #(.RESET_CODE(RESET_CODE)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart_w), .new_code(cfg_code_w),
    .tick(tick_w), .active_code(active_code_w), .fire(fire_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_expire  <= 1'b0;
      wd_rst_req <= 1'b0;
    end else begin
      wd_expire  <= fire_w;
      wd_rst_req <= fire_w && cfg_en_w;
    end
  end
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk
  import wdog_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  supply_low,
  input logic  wd_expire,
  input logic  wd_rst_req,
  input logic  kick,
  input logic  tick,
  input logic  fire,
  input logic  cfg_en,
  input code_t cfg_code,
  input code_t active_code
);
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> !wd_expire);

  assert_req_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_req |-> (wd_expire && $past(cfg_en)));

  assert_halt_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_halt(active_code) |-> !fire);

  assert_supply_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> !wd_expire);

  assert_kick_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (active_code == $past(cfg_code)));

  assert_fire_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> tick);
endmodule

bind wdog_timer wdog_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .wd_expire(wd_expire),
  .wd_rst_req(wd_rst_req), .kick(kick_w), .tick(tick_w), .fire(fire_w),
  .cfg_en(cfg_en_w), .cfg_code(cfg_code_w), .active_code(active_code_w)
);

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
  localparam int DIV = 4;
  localparam logic [7:0] CFG = 8'h0A;
  localparam logic [7:0] KICK = 8'h09;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic sys_rst_n = 1'b1;
  logic supply_low = 1'b0;
  logic wd_expire, wd_rst_req;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_timer #(.CLK_PER_TICK(DIV), .RESET_CODE(5'd2)) i_wdog_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sys_rst_n(sys_rst_n), .supply_low(supply_low),
    .wd_expire(wd_expire), .wd_rst_req(wd_rst_req)
  );

  function automatic int ticks(input int code);
    return (code == 0) ? 1 : code;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [7:0] d, output int k);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    k = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_expire(input int limit, output int e, output bit r);
    e = -1; r = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (wd_expire) begin e = cyc; r = wd_rst_req; return; end
    end
  endtask

  initial begin
    int k, e, e2, m, exp;
    bit r;
    bit quiet;
    @(negedge clk); @(negedge clk);
    // R11: reset state and counting from release with RESET_CODE=2, enable 0
    chk(wd_expire == 1'b0, "R11", wd_expire, 0);
    chk(wd_rst_req == 1'b0, "R11", wd_rst_req, 0);
    rst_n = 1'b1;
    m = cyc;
    wait_expire(100, e, r);
    chk(e == m + 2*DIV, "R11", e, m + 2*DIV);
    chk(r == 1'b0, "R11", r, 0);

    // R1, R2, R3, R6, R7: sweep of every running code with enable set
    for (int c = 0; c < 31; c++) begin
      write_reg(CFG, ((c % 2) != 0) ? (8'hE0 | 8'(c)) : (8'h80 | 8'(c)), k);
      write_reg(KICK, ((c % 2) != 0) ? 8'h5A : 8'h0A, k);
      wait_expire(200, e, r);
      exp = k + ticks(c) * DIV;
      chk(e == exp, "R1", e, exp);
      chk(r == 1'b1, "R7", r, 1);
      wait_expire(200, e2, r);
      chk(e2 == e + ticks(c) * DIV, "R6", e2, e + ticks(c) * DIV);
    end

    // R7: enable cleared, expiry still occurs without request
    write_reg(CFG, 8'h03, k);
    write_reg(KICK, 8'h0A, k);
    wait_expire(200, e, r);
    chk(e == k + 3*DIV, "R7", e, k + 3*DIV);
    chk(r == 1'b0, "R7", r, 0);

    // R4: wrong nibbles and other addresses leave timing alone
    write_reg(CFG, 8'h85, k);
    write_reg(KICK, 8'h0A, k);
    write_reg(KICK, 8'h05, m);
    write_reg(KICK, 8'h0B, m);
    write_reg(KICK, 8'hA0, m);
    write_reg(8'h0B, 8'h0A, m);
    write_reg(8'h00, 8'hFA, m);
    wait_expire(200, e, r);
    chk(e == k + 5*DIV, "R4", e, k + 5*DIV);

    // R5: new code written without restart is not used until the next kick
    write_reg(CFG, 8'h83, k);
    write_reg(KICK, 8'h0A, k);
    write_reg(CFG, 8'h8A, m);
    wait_expire(200, e, r);
    chk(e == k + 3*DIV, "R5", e, k + 3*DIV);
    wait_expire(200, e2, r);
    chk(e2 == e + 3*DIV, "R5", e2, e + 3*DIV);
    write_reg(KICK, 8'h0A, k);
    wait_expire(200, e, r);
    chk(e == k + 10*DIV, "R5", e, k + 10*DIV);

    // R8: all-ones code halts, then a normal code resumes
    write_reg(CFG, 8'h9F, k);
    write_reg(KICK, 8'h0A, k);
    wait_expire(300, e, r);
    chk(e == -1, "R8", e, -1);
    write_reg(CFG, 8'h81, k);
    write_reg(KICK, 8'h0A, k);
    wait_expire(200, e, r);
    chk(e == k + DIV, "R8", e, k + DIV);

    // R9: rising edge of sys_rst_n restarts the count
    write_reg(CFG, 8'h82, k);
    write_reg(KICK, 8'h0A, k);
    sys_rst_n = 1'b0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    sys_rst_n = 1'b1;
    m = cyc;
    wait_expire(200, e, r);
    chk(e == m + 1 + 2*DIV, "R9", e, m + 1 + 2*DIV);
    chk(r == 1'b1, "R9", r, 1);

    // R10: supply_low holds the counter idle
    write_reg(KICK, 8'h0A, k);
    supply_low = 1'b1;
    quiet = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (wd_expire || wd_rst_req) quiet = 1'b0;
    end
    chk(quiet, "R10", quiet, 1);
    supply_low = 1'b0;
    m = cyc;
    wait_expire(200, e, r);
    chk(e == m + 2*DIV, "R10", e, m + 2*DIV);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule